// File: doc/BRIEF.md
# Multi-channel prescaled countdown timer

This block is a bus-mapped timer with a parameterized number of identical channels. Each channel divides the core clock by a programmable prescale factor and uses the divided tick to count a 24-bit value down to expiry. A channel either runs once and halts at expiry, or runs continuously and reloads its starting value each time it expires. Every expiry sets a per-channel flag in a shared status word. A per-channel interrupt line is the flag gated by that channel's interrupt-enable bit.

Software programs a channel by writing its starting count and then its control word. It reads the live count back at any time. It acknowledges an expiry by writing a 1 to the channel's status bit. The bus is a plain single-cycle register port with combinational read data.

Top module: `tick_timer`

## Requirements
- R1: Control bits 7:0 hold a prescale value P. While a channel is enabled, its count decrements by one every P+1 clock cycles. The prescaler restarts from zero whenever the count is (re)loaded.
- R2: Control bits 28:27 select the mode: 01 is periodic and any other value is one-shot. In periodic mode, a tick that finds the count at 1 or 0 is an expiry, and it reloads the count from the starting-count register.
- R3: In one-shot mode, an expiry sets the count to 0 and clears the channel's enable bit (control bit 30), so the channel stops.
- R4: Each expiry sets the channel's flag, which is bit c of the status word for channel c. The channel's interrupt output is high exactly when that flag and control bit 29 are both set.
- R5: Writing the status word (address 0x80) clears every flag whose data bit is 1 and leaves flags written with 0 unchanged. An expiry in the same cycle keeps its flag set.
- R6: Writing a control word with bit 30 clear stops the channel. Its count then holds its value.
- R7: Only bits 23:0 of a starting-count write are kept. A write while the channel is enabled restarts the count from the new value.
- R8: Channel c occupies addresses c*16 (control), c*16+4 (starting count) and c*16+8 (live count, read-only). Reads return unused upper bits as zero.
- R9: After reset, every register, count and flag reads as zero and all interrupt outputs are low.
- R10: A control write that sets bit 30 on a stopped channel loads the count from the starting-count register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of the access |
| irq | output | NUM_CH | Per-channel interrupt (flag AND enable) |

## Verification
The count is tried with a small prescale in periodic mode, a zero prescale in one-shot mode and a large prescale with the full 24-bit count. Together these separate the tick rate, the reload-versus-halt choice at expiry and the width masking. Stop, re-enable and mid-run starting-count writes show whether the count holds, reloads or restarts, and whether the prescaler is cleared. Status writes with a mix of ones and zeros, some landing while a periodic channel keeps expiring, show the clear-by-one rule and its priority against a new expiry. A one-shot channel with its interrupt masked shows that the flag and the interrupt line are kept apart.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int BUS_W = 32;
  localparam int EN_BIT = 30;
  localparam int IE_BIT = 29;
  localparam int MODE_HI = 28;
  localparam int MODE_LO = 27;
  localparam int STAT_BIT = 7;

  typedef struct packed {
    logic run;
    logic restart;
    logic periodic;
  } chStrobe_t;
endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 24,
  parameter int PRE_W  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic [NUM_CH-1:0] expire,
  input  logic [CNT_W-1:0]  cnt     [NUM_CH],
  output chStrobe_t         strb    [NUM_CH],
  output logic [CNT_W-1:0]  loadVal [NUM_CH],
  output logic [PRE_W-1:0]  preVal  [NUM_CH],
  output logic [CNT_W-1:0]  initVal [NUM_CH],
  output logic [NUM_CH-1:0] flags,
  output logic [NUM_CH-1:0] irq
);
  logic [NUM_CH-1:0] enQ, ieQ, ctrlWr, initWr;
  logic [1:0]        modeQ [NUM_CH];
  logic              isStat, statWr;
  logic [2:0]        chSel;
  logic [1:0]        regSel;
  logic              unusedBus;

  assign isStat = busAddr[STAT_BIT];
  assign chSel  = busAddr[6:4];
  assign regSel = busAddr[3:2];
  assign statWr = busSel && busWr && isStat;
  assign unusedBus = ^{busWdata, busAddr};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ctrlWr[c] = busSel && busWr && !isStat && chSel == 3'(c) && regSel == 2'd0;
    assign initWr[c] = busSel && busWr && !isStat && chSel == 3'(c) && regSel == 2'd1;

    assign strb[c].run      = enQ[c];
    assign strb[c].restart  = (ctrlWr[c] && busWdata[EN_BIT] && !enQ[c]) || (initWr[c] && enQ[c]);
    assign strb[c].periodic = (modeQ[c] == 2'b01);
    assign loadVal[c] = initWr[c] ? busWdata[CNT_W-1:0] : initVal[c];
    assign irq[c] = flags[c] && ieQ[c];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enQ[c]     <= 1'b0;
        ieQ[c]     <= 1'b0;
        modeQ[c]   <= 2'b00;
        preVal[c]  <= '0;
        initVal[c] <= '0;
        flags[c]   <= 1'b0;
      end else begin
        if (ctrlWr[c]) begin
          enQ[c]    <= busWdata[EN_BIT];
          ieQ[c]    <= busWdata[IE_BIT];
          modeQ[c]  <= busWdata[MODE_HI:MODE_LO];
          preVal[c] <= busWdata[PRE_W-1:0];
        end else if (expire[c] && !strb[c].periodic) begin
          enQ[c] <= 1'b0;
        end
        if (initWr[c]) initVal[c] <= busWdata[CNT_W-1:0];
        if (expire[c]) flags[c] <= 1'b1;
        else if (statWr && busWdata[c]) flags[c] <= 1'b0;
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (isStat) begin
      busRdata[NUM_CH-1:0] = flags;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (chSel == 3'(c)) begin
          case (regSel)
            2'd0: begin
              busRdata[EN_BIT]          = enQ[c];
              busRdata[IE_BIT]          = ieQ[c];
              busRdata[MODE_HI:MODE_LO] = modeQ[c];
              busRdata[PRE_W-1:0]       = preVal[c];
            end
            2'd1:    busRdata[CNT_W-1:0] = initVal[c];
            2'd2:    busRdata[CNT_W-1:0] = cnt[c];
            default: busRdata = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 24,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  chStrobe_t         strb    [NUM_CH],
  input  logic [CNT_W-1:0]  loadVal [NUM_CH],
  input  logic [PRE_W-1:0]  preVal  [NUM_CH],
  output logic [CNT_W-1:0]  cnt     [NUM_CH],
  output logic [NUM_CH-1:0] expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [PRE_W-1:0] pc;
    logic             tick, atEnd;

    assign tick  = strb[c].run && (pc >= preVal[c]);
    assign atEnd = (cnt[c] <= ONE);
    assign expire[c] = tick && atEnd && !strb[c].restart;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pc     <= '0;
        cnt[c] <= '0;
      end else if (strb[c].restart) begin
        pc     <= '0;
        cnt[c] <= loadVal[c];
      end else if (strb[c].run) begin
        if (tick) begin
          pc <= '0;
          if (atEnd) cnt[c] <= strb[c].periodic ? loadVal[c] : '0;
          else       cnt[c] <= cnt[c] - ONE;
        end else begin
          pc <= pc + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 24,
  parameter int PRE_W  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [NUM_CH-1:0] irq
);
  chStrobe_t         strb    [NUM_CH];
  logic [CNT_W-1:0]  loadVal [NUM_CH];
  logic [PRE_W-1:0]  preVal  [NUM_CH];
  logic [CNT_W-1:0]  initArr [NUM_CH];
  logic [CNT_W-1:0]  cntArr  [NUM_CH];
  logic [NUM_CH-1:0] expire, flags;

  tick_timer_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .expire(expire), .cnt(cntArr),
    .strb(strb), .loadVal(loadVal), .preVal(preVal), .initVal(initArr),
    .flags(flags), .irq(irq)
  );

  tick_timer_dp #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadVal), .preVal(preVal),
    .cnt(cntArr), .expire(expire)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input chStrobe_t         strb    [NUM_CH],
  input logic [NUM_CH-1:0] expire,
  input logic [NUM_CH-1:0] flags,
  input logic [CNT_W-1:0]  cnt     [NUM_CH],
  input logic [CNT_W-1:0]  initVal [NUM_CH]
);
  logic anyWr;
  assign anyWr = busSel && busWr;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    AST_FLAG_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rstN)
      expire[c] |=> flags[c]); // R4
    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rstN)
      (expire[c] && !strb[c].periodic && !anyWr) |=> (!strb[c].run && cnt[c] == '0)); // R3
    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
      (expire[c] && strb[c].periodic && !anyWr) |=> (cnt[c] == initVal[c])); // R2
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
      (!strb[c].run && !strb[c].restart) |=> $stable(cnt[c])); // R6
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
      (strb[c].run && !strb[c].restart && !expire[c]) |=>
        (cnt[c] == $past(cnt[c]) || cnt[c] == $past(cnt[c]) - 1'b1)); // R1
  end
endmodule

bind tick_timer tick_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .strb(strb),
  .expire(expire), .flags(flags), .cnt(cntArr), .initVal(initArr)
);

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;
  localparam int NCH = 2;
  logic clk = 1'b0, rstN = 1'b0, busSel = 1'b0, busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [NCH-1:0] irq;
  int total = 0, bad = 0;
  bit finished = 0;

  tick_timer u_dut (.clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq));

  always #2.5 clk = ~clk;

  // behavioural reference state
  int mEn[NCH], mIe[NCH], mMode[NCH], mPre[NCH], mInit[NCH], mPc[NCH], mCnt[NCH], mFlag[NCH];

  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rstN) begin
        mEn[c] = 0; mIe[c] = 0; mMode[c] = 0; mPre[c] = 0;
        mInit[c] = 0; mPc[c] = 0; mCnt[c] = 0; mFlag[c] = 0;
      end else begin
        bit wC, wI, wS, rs, ex;
        int lv;
        wC = busSel && busWr && !busAddr[7] && busAddr[6:4] == c && busAddr[3:2] == 0;
        wI = busSel && busWr && !busAddr[7] && busAddr[6:4] == c && busAddr[3:2] == 1;
        wS = busSel && busWr && busAddr[7];
        rs = (wC && busWdata[30] && mEn[c] == 0) || (wI && mEn[c] != 0);
        lv = wI ? int'(busWdata[23:0]) : mInit[c];
        ex = 0;
        if (rs) begin mPc[c] = 0; mCnt[c] = lv; end
        else if (mEn[c] != 0) begin
          if (mPc[c] >= mPre[c]) begin
            mPc[c] = 0;
            if (mCnt[c] <= 1) begin ex = 1; mCnt[c] = (mMode[c] == 1) ? lv : 0; end
            else mCnt[c] = mCnt[c] - 1;
          end else mPc[c] = mPc[c] + 1;
        end
        if (ex) mFlag[c] = 1;
        else if (wS && busWdata[c]) mFlag[c] = 0;
        if (wC) begin
          mEn[c] = busWdata[30]; mIe[c] = busWdata[29];
          mMode[c] = busWdata[28:27]; mPre[c] = busWdata[7:0];
        end else if (ex && mMode[c] != 1) mEn[c] = 0;
        if (wI) mInit[c] = busWdata[23:0];
      end
    end
  end

  function automatic logic [31:0] modelRead(logic [7:0] a);
    logic [31:0] r = '0;
    int c = a[6:4];
    if (a[7]) begin
      for (int k = 0; k < NCH; k++) r[k] = mFlag[k][0];
    end else if (c < NCH) begin
      case (a[3:2])
        2'd0: r = {1'b0, mEn[c][0], mIe[c][0], mMode[c][1:0], 19'd0, mPre[c][7:0]};
        2'd1: r = 32'(mInit[c]);
        2'd2: r = 32'(mCnt[c]);
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-clock comparison of the interrupt lines (R4)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic [NCH-1:0] e;
      for (int c = 0; c < NCH; c++) e[c] = (mFlag[c] != 0) && (mIe[c] != 0);
      chk("R4 irq", 32'(irq), 32'(e));
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk); busSel = 0; busWr = 0;
  endtask

  task automatic rdM(logic [7:0] a, string tag);
    @(negedge clk); busSel = 1; busWr = 0; busAddr = a; #1;
    chk(tag, busRdata, modelRead(a));
  endtask

  task automatic rdL(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk); busSel = 1; busWr = 0; busAddr = a; #1;
    chk(tag, busRdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    logic [31:0] held;
    repeat (4) @(negedge clk);
    rstN = 1;
    // R9 reset state
    rdL(8'h00, 32'h0, "R9 ctrl0");
    rdL(8'h04, 32'h0, "R9 init0");
    rdL(8'h18, 32'h0, "R9 count1");
    rdL(8'h80, 32'h0, "R9 status");
    chk("R9 irq", 32'(irq), 32'h0);

    // R1 R2 periodic, prescale 2, count 5, interrupt on
    wr(8'h04, 32'd5);
    wr(8'h00, 32'h6800_0002);
    for (int i = 0; i < 40; i++) rdM(8'h08, "R1 R2 periodic count");
    rdM(8'h00, "R2 ctrl stays enabled");
    rdM(8'h80, "R4 flag set");
    wr(8'h80, 32'h1);
    rdM(8'h80, "R5 clear by one");
    wr(8'h80, 32'h0);
    rdM(8'h80, "R5 zero write no effect");

    // R6 stop holds count
    wr(8'h00, 32'h0);
    rdM(8'h08, "R6 count after stop");
    held = busRdata;
    idle(12);
    rdL(8'h08, held, "R6 count held");

    // R10 restart loads from starting count, prescale 3
    wr(8'h00, 32'h4000_0003);
    rdL(8'h08, 32'd5, "R10 reload on enable");
    for (int i = 0; i < 10; i++) rdM(8'h08, "R1 prescale 3 count");

    // R7 mid-run starting-count write restarts
    wr(8'h04, 32'hAB00_0010);
    rdL(8'h08, 32'h10, "R7 restart value");
    rdL(8'h04, 32'h10, "R7 init masked");
    for (int i = 0; i < 8; i++) rdM(8'h08, "R7 count after restart");

    // R3 one-shot on channel 1, no interrupt enable
    wr(8'h14, 32'd3);
    wr(8'h10, 32'h4000_0000);
    idle(10);
    rdL(8'h10, 32'h0, "R3 enable cleared");
    rdL(8'h18, 32'h0, "R3 count zero");
    rdM(8'h80, "R4 flag1 set");
    chk("R4 masked irq1", 32'(irq[1]), 32'h0);

    // R8 R7 full-width count with large prescale
    wr(8'h10, 32'h4800_00FF);
    wr(8'h14, 32'hFFFF_FFFF);
    rdL(8'h14, 32'h00FF_FFFF, "R7 init all ones");
    rdL(8'h18, 32'h00FF_FFFF, "R8 count upper zero");
    rdL(8'h1C, 32'h0, "R8 unused slot");

    // R5 clear all
    wr(8'h00, 32'h0);
    wr(8'h10, 32'h0);
    wr(8'h80, 32'h1F);
    rdL(8'h80, 32'h0, "R5 clear all");
    idle(3);
    finish_up();
  end
endmodule